// File: doc/BRIEF.md
# Microprogrammed Control Sequencer

This block is the control unit of a small multicycle processor. A state register holds the address of the current control state. That address reads a control-store word. The word supplies the control signals for the current cycle and also says how the following address is formed. The datapath is outside this block; it sees only the control-signal bus and the state address.

The next address comes from one of two paths. On a dispatch state it is the 4-bit opcode, zero-extended to 6 bits. On every other state it is a base address stored in the word, and one condition input chosen by a select field can set a single low-order bit of that base. The possible conditions are memory ready, branch enable, addressing mode, privilege and interrupt request. This keeps the stored microprogram small: a two-way branch needs only two words whose addresses differ in one bit. Memory-access states use the memory-ready condition and loop on their own address until memory answers.

A reset reloads the built-in microprogram into the store. A load port, used only for testing, can overwrite any word.

Top module: `ucu_top`

## Requirements
- R1: While reset is asserted, and at the first edge after it is released, the state address is 18. Reset reloads every control-store word with its built-in value.
- R2: From state 18, with the interrupt request low, the next state is 33.
- R3: In state 33 the state address holds at 33 for as long as memory ready is low. It moves to 35 on the first edge at which memory ready is high.
- R4: State 35 goes to 32. State 32 is a dispatch state, and the next address is {2'b00, opcode}.
- R5: State 0 (opcode 0) goes to 22 when branch enable is high and to 18 when it is low. State 22 returns to 18.
- R6: State 18 with the interrupt request high goes to 49. State 49 returns to 18.
- R7: State 4 (opcode 4) goes to 21 when the addressing-mode bit is 1 and to 20 when it is 0.
- R8: State 8 (opcode 8) goes to 44 when the privilege bit is 1 and to 36 when it is 0.
- R9: Word layout: base address in bits [5:0], condition select in [8:6], dispatch flag in [9], control signals in [21:10]. Select codes are 1 for ready (bit 1), 2 for branch enable (bit 2), 3 for mode (bit 0), 4 for privilege (bit 3) and 5 for interrupt (bit 4). Codes 0, 6 and 7 select nothing. Condition inputs that are not selected have no effect on the next address.
- R10: The control output is the control field of the word at the current state address. Built-in values: state 18 gives 0x007, state 33 gives 0x018, states 1 and 9 give 0x380, state 0 gives 0x000.
- R11: A load-port write takes effect at the clock edge. The next address computed in the cycle of the write uses the old word. From the following cycle on, both the control output and the next address use the new word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| opcode | input | 4 | Opcode of the current instruction |
| irq | input | 1 | Interrupt request |
| ben | input | 1 | Branch enable condition |
| mode | input | 1 | Addressing-mode bit |
| priv | input | 1 | Privilege bit |
| mem_ready | input | 1 | Memory access complete |
| load_en | input | 1 | Test write enable for the control store |
| load_addr | input | 6 | Test write address |
| load_word | input | 22 | Test write data, in the layout of R9 |
| state_addr | output | 6 | Registered current state address |
| ctrl | output | 12 | Control signals of the current state |

## Verification
A load-port write to the current state's own word and that state's next-address decision can happen in the same cycle. The bench provokes this while the sequencer is waiting in state 33 with memory ready low. It writes a word there with base 40 and no condition. It then expects state 33 again after that edge, because the old word decided, while the control output already shows the new value. At the next edge it expects state 40 even though memory ready is still low. A reset afterwards must bring the original word back, which shows as state 33 waiting again.

// File: rtl/ucu_pkg.sv
package ucu_pkg;
  localparam int ADDR_W = 6;
  localparam int OPC_W  = 4;
  localparam int CTRL_W = 12;
  localparam int SEL_W  = 3;
  localparam int WORD_W = CTRL_W + 1 + SEL_W + ADDR_W;
  localparam int DEPTH  = 1 << ADDR_W;

  typedef struct packed {
    logic [CTRL_W-1:0] ctrl;
    logic              disp;
    logic [SEL_W-1:0]  csel;
    logic [ADDR_W-1:0] base;
  } uword_t;

  // condition select codes
  localparam logic [SEL_W-1:0] SEL_NONE  = 3'd0;
  localparam logic [SEL_W-1:0] SEL_READY = 3'd1;
  localparam logic [SEL_W-1:0] SEL_BEN   = 3'd2;
  localparam logic [SEL_W-1:0] SEL_MODE  = 3'd3;
  localparam logic [SEL_W-1:0] SEL_PRIV  = 3'd4;
  localparam logic [SEL_W-1:0] SEL_IRQ   = 3'd5;

  // control signal bit positions
  localparam int C_LD_MAR   = 0;
  localparam int C_LD_PC    = 1;
  localparam int C_GATE_PC  = 2;
  localparam int C_LD_MDR   = 3;
  localparam int C_MEM_EN   = 4;
  localparam int C_LD_IR    = 5;
  localparam int C_GATE_MDR = 6;
  localparam int C_LD_REG   = 7;
  localparam int C_GATE_ALU = 8;
  localparam int C_LD_CC    = 9;
  localparam int C_LD_BEN   = 10;
  localparam int C_IRQ_ACK  = 11;

  function automatic logic [CTRL_W-1:0] cbit(input int pos);
    logic [CTRL_W-1:0] v;
    v = '0;
    v[pos] = 1'b1;
    return v;
  endfunction

  function automatic uword_t mk(input logic [CTRL_W-1:0] c, input logic d,
                                input logic [SEL_W-1:0] s, input int b);
    uword_t w;
    w.ctrl = c;
    w.disp = d;
    w.csel = s;
    w.base = ADDR_W'(b);
    return w;
  endfunction

  // built-in microprogram
  function automatic uword_t default_word(input int a);
    case (a)
      18: return mk(cbit(C_LD_MAR) | cbit(C_LD_PC) | cbit(C_GATE_PC), 1'b0, SEL_IRQ, 33);
      33: return mk(cbit(C_LD_MDR) | cbit(C_MEM_EN), 1'b0, SEL_READY, 33);
      35: return mk(cbit(C_LD_IR) | cbit(C_GATE_MDR), 1'b0, SEL_NONE, 32);
      32: return mk(cbit(C_LD_BEN), 1'b1, SEL_NONE, 0);
      0:  return mk('0, 1'b0, SEL_BEN, 18);
      22: return mk(cbit(C_LD_PC), 1'b0, SEL_NONE, 18);
      1, 9: return mk(cbit(C_LD_REG) | cbit(C_GATE_ALU) | cbit(C_LD_CC), 1'b0, SEL_NONE, 18);
      4:  return mk(cbit(C_LD_PC), 1'b0, SEL_MODE, 20);
      8:  return mk('0, 1'b0, SEL_PRIV, 36);
      49: return mk(cbit(C_IRQ_ACK), 1'b0, SEL_NONE, 18);
      default: return mk('0, 1'b0, SEL_NONE, 18);
    endcase
  endfunction

  // base address with the selected condition OR-ed into its bit
  function automatic logic [ADDR_W-1:0] modify(input uword_t w, input logic rdy,
      input logic br, input logic md, input logic pv, input logic iq);
    logic [ADDR_W-1:0] m;
    m = '0;
    case (w.csel)
      SEL_READY: m[1] = rdy;
      SEL_BEN:   m[2] = br;
      SEL_MODE:  m[0] = md;
      SEL_PRIV:  m[3] = pv;
      SEL_IRQ:   m[4] = iq;
      default:   m = '0;
    endcase
    return w.base | m;
  endfunction
endpackage

// File: rtl/ucu_store.sv
module ucu_store
  import ucu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] rd_addr,
  output uword_t            rd_word,
  input  logic              ld_en,
  input  logic [ADDR_W-1:0] ld_addr,
  input  uword_t            ld_word
);
  uword_t mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= default_word(i);
    end else if (ld_en) begin
      mem[ld_addr] <= ld_word;
    end
  end

  assign rd_word = mem[rd_addr];

  AST_LOAD_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    ld_en |=> mem[$past(ld_addr)] == $past(ld_word)); // R11
endmodule

// File: rtl/ucu_seq.sv
module ucu_seq
  import ucu_pkg::*;
(
  input  uword_t            word,
  input  logic [OPC_W-1:0]  opcode,
  input  logic              irq,
  input  logic              ben,
  input  logic              mode,
  input  logic              priv,
  input  logic              mem_ready,
  output logic [ADDR_W-1:0] nxt_addr,
  output logic              dispatch_taken
);
  localparam int PAD_W = ADDR_W - OPC_W;

  assign dispatch_taken = word.disp;

  always_comb begin
    if (word.disp) nxt_addr = {{PAD_W{1'b0}}, opcode};
    else           nxt_addr = modify(word, mem_ready, ben, mode, priv, irq);
  end
endmodule

// File: rtl/ucu_top.sv
module ucu_top
  import ucu_pkg::*;
#(
  parameter int RESET_ADDR = 18
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [OPC_W-1:0]     opcode,
  input  logic                 irq,
  input  logic                 ben,
  input  logic                 mode,
  input  logic                 priv,
  input  logic                 mem_ready,
  input  logic                 load_en,
  input  logic [ADDR_W-1:0]    load_addr,
  input  logic [WORD_W-1:0]    load_word,
  output logic [ADDR_W-1:0]    state_addr,
  output logic [CTRL_W-1:0]    ctrl
);
  localparam logic [ADDR_W-1:0] RST_A = ADDR_W'(RESET_ADDR);
  localparam int PAD_W = ADDR_W - OPC_W;

  logic [ADDR_W-1:0] state_q;
  logic [ADDR_W-1:0] nxt_addr;
  logic              dispatch_taken;
  uword_t            cur_word;
  uword_t            ld_w;

  assign ld_w = uword_t'(load_word);

  ucu_store u_store (
    .clk(clk), .rst_n(rst_n), .rd_addr(state_q), .rd_word(cur_word),
    .ld_en(load_en), .ld_addr(load_addr), .ld_word(ld_w)
  );

  ucu_seq u_seq (
    .word(cur_word), .opcode(opcode), .irq(irq), .ben(ben), .mode(mode),
    .priv(priv), .mem_ready(mem_ready), .nxt_addr(nxt_addr),
    .dispatch_taken(dispatch_taken)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= RST_A;
    else        state_q <= nxt_addr;
  end

  assign state_addr = state_q;
  assign ctrl       = cur_word.ctrl;

  AST_RESET_ADDR: assert property (@(posedge clk)
    $rose(rst_n) |-> state_q == RST_A); // R1
  AST_DISPATCH: assert property (@(posedge clk) disable iff (!rst_n)
    dispatch_taken |=> state_q == {{PAD_W{1'b0}}, $past(opcode)}); // R4
  AST_WAIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!cur_word.disp && cur_word.csel == SEL_READY && !mem_ready)
      |=> state_q == $past(cur_word.base)); // R3
  AST_PLAIN_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (!cur_word.disp && (cur_word.csel == SEL_NONE || cur_word.csel > SEL_IRQ))
      |=> state_q == $past(cur_word.base)); // R9
endmodule

// File: tb/sim_ucu_top.sv
module sim_ucu_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] opcode = '0;
  logic irq = 0, ben = 0, mode = 0, priv = 0, mem_ready = 0;
  logic load_en = 0;
  logic [5:0] load_addr = '0;
  logic [21:0] load_word = '0;
  logic [5:0] state_addr;
  logic [11:0] ctrl;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  ucu_top u0 (
    .clk(clk), .rst_n(rst_n), .opcode(opcode), .irq(irq), .ben(ben),
    .mode(mode), .priv(priv), .mem_ready(mem_ready), .load_en(load_en),
    .load_addr(load_addr), .load_word(load_word), .state_addr(state_addr),
    .ctrl(ctrl)
  );

  task automatic chk_state(input logic [5:0] exp, input string req);
    checks++;
    if (state_addr !== exp) begin
      errors++;
      $display("FAIL %s state actual %0d expected %0d", req, state_addr, exp);
    end
  endtask

  task automatic chk_ctrl(input logic [11:0] exp, input string req);
    checks++;
    if (ctrl !== exp) begin
      errors++;
      $display("FAIL %s ctrl actual %h expected %h", req, ctrl, exp);
    end
  endtask

  task automatic step(input logic [5:0] exp, input string req);
    @(posedge clk); #2;
    chk_state(exp, req);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    @(posedge clk); #2;
    chk_state(6'd18, "R1");
    @(posedge clk); #2;
    rst_n = 1'b1;
  endtask

  // 18 -> 33 -> 35 -> 32 with memory ready
  task automatic fetch_to_dispatch();
    irq = 0; mem_ready = 1;
    step(6'd33, "R2");
    step(6'd35, "R3");
    step(6'd32, "R4");
  endtask

  task automatic t_reset();
    do_reset();
    chk_state(6'd18, "R1");
    chk_ctrl(12'h007, "R10");
    step(6'd33, "R1");
  endtask

  task automatic t_fetch_wait();
    do_reset();
    irq = 0; mem_ready = 0;
    step(6'd33, "R2");
    chk_ctrl(12'h018, "R10");
    ben = 1; irq = 1; mode = 1; priv = 1;
    step(6'd33, "R3");
    step(6'd33, "R9");
    ben = 0; irq = 0; mode = 0; priv = 0;
    mem_ready = 1;
    step(6'd35, "R3");
    step(6'd32, "R4");
    opcode = 4'd9;
    step(6'd9, "R4");
    chk_ctrl(12'h380, "R10");
    step(6'd18, "R9");
  endtask

  task automatic t_branch();
    opcode = 4'd0; ben = 0;
    fetch_to_dispatch();
    step(6'd0, "R4");
    chk_ctrl(12'h000, "R10");
    step(6'd18, "R5");
    fetch_to_dispatch();
    ben = 1;
    step(6'd0, "R4");
    step(6'd22, "R5");
    ben = 0;
    step(6'd18, "R5");
  endtask

  task automatic t_irq();
    irq = 1;
    step(6'd49, "R6");
    irq = 0;
    step(6'd18, "R6");
  endtask

  task automatic t_mode_priv();
    opcode = 4'd4; mode = 1;
    fetch_to_dispatch();
    step(6'd4, "R4");
    step(6'd21, "R7");
    step(6'd18, "R7");
    mode = 0;
    fetch_to_dispatch();
    step(6'd4, "R4");
    step(6'd20, "R7");
    step(6'd18, "R7");
    opcode = 4'd8; priv = 1;
    fetch_to_dispatch();
    step(6'd8, "R4");
    step(6'd44, "R8");
    step(6'd18, "R8");
    priv = 0;
    fetch_to_dispatch();
    step(6'd8, "R4");
    step(6'd36, "R8");
    step(6'd18, "R8");
    opcode = 4'd1;
    fetch_to_dispatch();
    step(6'd1, "R4");
    chk_ctrl(12'h380, "R10");
    step(6'd18, "R9");
  endtask

  // write the waiting state's own word in the cycle it decides
  task automatic t_load_collide();
    irq = 0; mem_ready = 0;
    step(6'd33, "R2");
    load_en = 1; load_addr = 6'd33;
    load_word = {12'h0AB, 1'b0, 3'd0, 6'd40};
    step(6'd33, "R11");
    chk_ctrl(12'h0AB, "R11");
    load_en = 0;
    step(6'd40, "R11");
    step(6'd18, "R9");
    do_reset();
    step(6'd33, "R1");
    chk_ctrl(12'h018, "R1");
    step(6'd33, "R3");
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    t_reset();
    t_fetch_wait();
    t_branch();
    t_irq();
    t_mode_priv();
    t_load_collide();
    finish_run();
  end
endmodule